// File: doc/BRIEF.md
# Single-Channel Memory-to-Stream DMA Engine

This block moves a block of 32-bit words from memory onto a word-wide valid/ready/last stream. Software programs a source address and a word count through a small register bus, then arms the channel by setting the start bit in the control register. The start address and the count are copied into the engine at that moment. The engine then works one word at a time. It issues a read request, waits for the returned word, and presents that word on the stream until the sink accepts it. It then moves on to the next word, four bytes higher in memory.

The engine declares completion only after the sink has accepted the final beat, which carries the last flag. It then raises a one-cycle interrupt and bumps a read-only completion counter. That counter saturates and never goes down. An event port reports each accepted configuration write, each start, each accepted beat and each completion, so that a trace or debug unit can follow the channel's progress.

Top module: `dma_stream_ch`

## Requirements
- R1: Bits [3:2] of the register address select the register: 0 is the source address (offset 0x00), 1 is the word count (0x04), 2 is control (0x08) and 3 is the completion counter (0x0C). Read data appears on `reg_rdata` on the cycle after the read strobe, and an idle channel returns the last value written to the address and count registers.
- R2: A write to control with bit 0 set, made while the channel is idle, starts a transfer using the address and count held at that moment. Control bit 0 reads as 1 while the transfer runs and as 0 once it has completed.
- R3: Each beat makes exactly one single-cycle read request. The address of beat i is start address + 4*i. No new request is issued while a read is outstanding.
- R4: A beat transfers only on a cycle where `st_valid` and `st_ready` are both high. While the sink stalls, `st_valid`, `st_data` and `st_last` hold their values, and the data sent for beat i is the word memory returned for that beat's request.
- R5: A transfer with count N sends exactly N beats, and `st_last` is high on beat N-1 only.
- R6: `irq_done` is a one-cycle pulse that rises two cycles after the edge that accepts the final beat. It never rises before that beat is accepted, however long the sink stalls.
- R7: The completion counter rises by exactly one with each interrupt, saturates at its maximum and never decreases. Writes to it are ignored.
- R8: A start with a count of 0 issues no memory reads and no beats, and still completes with an interrupt and a counter increment.
- R9: While a transfer runs, all register writes are ignored. They change no register, start nothing and produce no event.
- R10: The event port gives one cycle of `evt_valid` per occurrence, with `evt_kind` set as follows. 0 is a configuration write (address = register offset, info = written data). 1 is a start (address = start address, info = count). 2 is an accepted beat (address = that beat's source address, info = words still to send). 3 is a completion (info = 0).
- R11: After reset, all registers read 0 and `st_valid`, `mem_req`, `irq_done` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream beat valid |
| st_data | output | 32 | Stream beat data |
| st_last | output | 1 | Final beat of the block |
| st_ready | input | 1 | Stream sink ready |
| irq_done | output | 1 | Completion interrupt pulse |
| done_count | output | DONE_W | Saturating completion counter |
| evt_valid | output | 1 | Event strobe |
| evt_kind | output | 2 | Event kind code |
| evt_addr | output | ADDR_W | Event address field |
| evt_info | output | 32 | Event data or count field |

## Verification
The assertions check the local rules of the handshakes on every cycle. They cover data holding under stall, single-cycle requests and interrupts, the fixed delay from the final accepted beat to the interrupt, the monotonic counter, and quiet outputs while idle. Only the bench scenarios can show the end-to-end properties. These are the address sequence and data contents across a block, the exact beat count and the placement of the last flag, the zero-length case, the silent rejection of writes during a transfer, and the event payloads compared against the programmed values.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_SEND  = 2'd2,
    S_DONE  = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    EV_CFG   = 2'd0,
    EV_START = 2'd1,
    EV_BEAT  = 2'd2,
    EV_DONE  = 2'd3
  } evt_kind_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_DCNT = 2'd3;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DONE_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic [DONE_W-1:0] done_count,
  output logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] src_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              start,
  output logic              cfg_wr,
  output logic [REG_AW-1:0] cfg_off,
  output logic [WORD_W-1:0] cfg_data
);

  logic [1:0] sel;
  logic       accept;

  assign sel      = addr[3:2];
  assign accept   = wr_en && !busy;
  assign start    = accept && (sel == SEL_CTRL) && wdata[0];
  assign cfg_wr   = accept && !start && (sel != SEL_DCNT);
  assign cfg_off  = addr;
  assign cfg_data = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      len_q <= '0;
    end else if (accept) begin
      if (sel == SEL_SRC) src_q <= wdata[ADDR_W-1:0];
      if (sel == SEL_LEN) len_q <= wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_SRC:  rdata <= WORD_W'(src_q);
        SEL_LEN:  rdata <= WORD_W'(len_q);
        SEL_CTRL: rdata <= WORD_W'(busy);
        default:  rdata <= WORD_W'(done_count);
      endcase
    end
  end

endmodule

// File: rtl/dma_done_ctr.sv
module dma_done_ctr #(
  parameter int DONE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [DONE_W-1:0] count
);

  localparam logic [DONE_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + DONE_W'(1);
    end
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DONE_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [LEN_W-1:0]  len_q,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_off,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              st_ready,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              st_valid,
  output logic [WORD_W-1:0] st_data,
  output logic              st_last,
  output logic              irq_done,
  output logic [DONE_W-1:0] done_count,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [WORD_W-1:0] evt_info
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

  eng_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              fin_beat;

  assign mem_addr = cur_addr;
  assign fin_beat = (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      remain    <= '0;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      st_valid  <= 1'b0;
      st_data   <= '0;
      st_last   <= 1'b0;
      irq_done  <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= EV_CFG;
      evt_addr  <= '0;
      evt_info  <= '0;
    end else begin
      mem_req   <= 1'b0;
      irq_done  <= 1'b0;
      evt_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            cur_addr  <= src_q;
            remain    <= len_q;
            busy      <= 1'b1;
            evt_valid <= 1'b1;
            evt_kind  <= EV_START;
            evt_addr  <= src_q;
            evt_info  <= WORD_W'(len_q);
            if (len_q == '0) begin
              state <= S_DONE;
            end else begin
              state   <= S_FETCH;
              mem_req <= 1'b1;
            end
          end else if (cfg_wr) begin
            evt_valid <= 1'b1;
            evt_kind  <= EV_CFG;
            evt_addr  <= ADDR_W'(cfg_off);
            evt_info  <= cfg_data;
          end
        end
        S_FETCH: begin
          if (mem_rvalid) begin
            st_valid <= 1'b1;
            st_data  <= mem_rdata;
            st_last  <= fin_beat;
            state    <= S_SEND;
          end
        end
        S_SEND: begin
          if (st_ready) begin
            st_valid  <= 1'b0;
            st_last   <= 1'b0;
            evt_valid <= 1'b1;
            evt_kind  <= EV_BEAT;
            evt_addr  <= cur_addr;
            evt_info  <= WORD_W'(remain - ONE);
            cur_addr  <= cur_addr + STEP;
            remain    <= remain - ONE;
            if (fin_beat) begin
              state <= S_DONE;
            end else begin
              state   <= S_FETCH;
              mem_req <= 1'b1;
            end
          end
        end
        default: begin
          irq_done  <= 1'b1;
          busy      <= 1'b0;
          evt_valid <= 1'b1;
          evt_kind  <= EV_DONE;
          evt_addr  <= cur_addr;
          evt_info  <= '0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  dma_done_ctr #(.DONE_W(DONE_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (state == S_DONE),
    .count (done_count)
  );

endmodule

// File: rtl/dma_stream_ch.sv
module dma_stream_ch
  import dma_stream_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DONE_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              st_valid,
  output logic [31:0]       st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              irq_done,
  output logic [DONE_W-1:0] done_count,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [31:0]       evt_info
);

  logic              busy;
  logic [ADDR_W-1:0] src_q;
  logic [LEN_W-1:0]  len_q;
  logic              start;
  logic              cfg_wr;
  logic [REG_AW-1:0] cfg_off;
  logic [31:0]       cfg_data;

  dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DONE_W(DONE_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .rd_en      (reg_rd_en),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .busy       (busy),
    .done_count (done_count),
    .rdata      (reg_rdata),
    .src_q      (src_q),
    .len_q      (len_q),
    .start      (start),
    .cfg_wr     (cfg_wr),
    .cfg_off    (cfg_off),
    .cfg_data   (cfg_data)
  );

  dma_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DONE_W(DONE_W), .REG_AW(REG_AW)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_q      (src_q),
    .len_q      (len_q),
    .cfg_wr     (cfg_wr),
    .cfg_off    (cfg_off),
    .cfg_data   (cfg_data),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .st_ready   (st_ready),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .st_valid   (st_valid),
    .st_data    (st_data),
    .st_last    (st_last),
    .irq_done   (irq_done),
    .done_count (done_count),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .evt_addr   (evt_addr),
    .evt_info   (evt_info)
  );

endmodule

// File: rtl/dma_stream_ch_chk.sv
module dma_stream_ch_chk #(
  parameter int DONE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req,
  input logic              st_valid,
  input logic [31:0]       st_data,
  input logic              st_last,
  input logic              st_ready,
  input logic              irq_done,
  input logic [DONE_W-1:0] done_count,
  input logic              evt_valid,
  input logic [1:0]        evt_kind
);

  localparam logic [DONE_W-1:0] CNT_MAX = '1;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last)); // R4

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done); // R6

  AST_LAST_TO_IRQ: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ready && st_last |=> !irq_done ##1 irq_done); // R6

  AST_DONE_MONO: assert property (@(posedge clk) disable iff (rst)
    done_count >= $past(done_count)); // R7

  AST_DONE_STEP: assert property (@(posedge clk) disable iff (rst)
    irq_done && ($past(done_count) != CNT_MAX) |-> done_count == $past(done_count) + DONE_W'(1)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !st_valid && !mem_req); // R2

  AST_BEAT_EVENT: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ready |=> evt_valid && evt_kind == 2'd2); // R10

endmodule

bind dma_stream_ch dma_stream_ch_chk #(.DONE_W(DONE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mem_req    (mem_req),
  .st_valid   (st_valid),
  .st_data    (st_data),
  .st_last    (st_last),
  .st_ready   (st_ready),
  .irq_done   (irq_done),
  .done_count (done_count),
  .evt_valid  (evt_valid),
  .evt_kind   (evt_kind)
);

// File: tb/sim_dma_stream_ch.sv
module sim_dma_stream_ch;

  localparam int AW   = 32;
  localparam int LW   = 16;
  localparam int DW   = 3;
  localparam int RAW  = 4;
  localparam int DMAX = (1 << DW) - 1;

  logic           clk = 1'b0;
  logic           rst;
  logic           reg_wr_en, reg_rd_en;
  logic [RAW-1:0] reg_addr;
  logic [31:0]    reg_wdata, reg_rdata;
  logic           mem_req, mem_rvalid;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    mem_rdata;
  logic           st_valid, st_last, st_ready;
  logic [31:0]    st_data;
  logic           irq_done;
  logic [DW-1:0]  done_count;
  logic           evt_valid;
  logic [1:0]     evt_kind;
  logic [AW-1:0]  evt_addr;
  logic [31:0]    evt_info;

  always #5 clk = ~clk;

  dma_stream_ch #(.ADDR_W(AW), .LEN_W(LW), .DONE_W(DW), .REG_AW(RAW)) u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .st_valid(st_valid), .st_data(st_data),
    .st_last(st_last), .st_ready(st_ready), .irq_done(irq_done),
    .done_count(done_count), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .evt_info(evt_info)
  );

  int checks = 0;
  int errors = 0;

  // expectation state
  logic [31:0] x_src = '0;
  int          x_len = 0;
  int          req_idx = 0, beat_idx = 0, ev_beat_idx = 0;
  int          irq_cnt = 0, cfg_ev_cnt = 0, start_ev_cnt = 0, done_ev_cnt = 0;
  int          completions = 0;
  bit          fin_seen = 0;
  int          fin_age = 0;
  int          ready_pct = 100;
  bit          hold_prev = 0;
  logic [31:0] hold_data;
  logic        hold_last;
  logic [3:0]  w_off = '0;
  logic [31:0] w_data = '0;
  bit          pend = 0;
  int          lat = 0;
  logic [31:0] paddr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic int sat_cnt(input int n);
    return (n > DMAX) ? DMAX : n;
  endfunction

  // memory model, sink and monitors: one process at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mem_rvalid = 1'b0;
      st_ready   = 1'b0;
      mem_rdata  = '0;
    end else begin
      if (fin_seen) fin_age++;
      if (irq_done) begin
        irq_cnt++;
        check(beat_idx == x_len, "R6", "beats accepted before irq", beat_idx, x_len);
        if (x_len > 0)
          check(fin_seen && fin_age == 2, "R6", "irq delay after last beat", fin_age, 2);
        fin_seen = 0;
      end
      if (hold_prev)
        check(st_valid && st_data == hold_data && st_last == hold_last,
              "R4", "stalled beat changed", st_data, hold_data);
      st_ready = ($urandom_range(0, 99) < ready_pct);
      hold_prev = st_valid && !st_ready;
      hold_data = st_data;
      hold_last = st_last;
      if (st_valid && st_ready) begin
        check(st_data == mem_word(x_src + 4 * beat_idx), "R4", "beat data",
              st_data, mem_word(x_src + 4 * beat_idx));
        check(st_last == (beat_idx == x_len - 1), "R5", "last flag", st_last,
              (beat_idx == x_len - 1));
        beat_idx++;
        if (st_last) begin
          fin_seen = 1;
          fin_age  = 0;
        end
      end
      if (evt_valid) begin
        case (evt_kind)
          2'd0: begin
            cfg_ev_cnt++;
            check(evt_addr == 32'(w_off) && evt_info == w_data, "R10", "cfg event",
                  evt_info, w_data);
          end
          2'd1: begin
            start_ev_cnt++;
            check(evt_addr == x_src && evt_info == 32'(x_len), "R10", "start event",
                  evt_addr, x_src);
          end
          2'd2: begin
            check(evt_addr == x_src + 4 * ev_beat_idx && evt_info == 32'(x_len - 1 - ev_beat_idx),
                  "R10", "beat event", evt_info, x_len - 1 - ev_beat_idx);
            ev_beat_idx++;
          end
          default: begin
            done_ev_cnt++;
            check(evt_info == 0, "R10", "done event info", evt_info, 0);
          end
        endcase
      end
      mem_rvalid = 1'b0;
      if (mem_req) begin
        check(!pend, "R3", "request while read outstanding", pend, 0);
        check(mem_addr == x_src + 4 * req_idx, "R3", "request address", mem_addr,
              x_src + 4 * req_idx);
        req_idx++;
        pend  = 1;
        paddr = mem_addr;
        lat   = $urandom_range(0, 3);
      end
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(paddr);
          pend = 0;
        end else begin
          lat--;
        end
      end
    end
  end

  task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    w_off = off; w_data = d;
    reg_addr = off; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_addr = off; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int base);
    while (irq_cnt == base) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] src, input int len, input int rp);
    int irq0, done0;
    logic [31:0] rd;
    ready_pct = rp;
    reg_write(4'h0, src);
    reg_write(4'h4, 32'(len));
    x_src = src; x_len = len;
    req_idx = 0; beat_idx = 0; ev_beat_idx = 0;
    irq0 = irq_cnt; done0 = done_ev_cnt;
    reg_write(4'h8, 32'h1);
    wait_irq(irq0);
    completions++;
    if (len == 0) begin
      check(req_idx == 0, "R8", "reads on empty block", req_idx, 0);
      check(beat_idx == 0, "R8", "beats on empty block", beat_idx, 0);
    end else begin
      check(req_idx == len, "R3", "request count", req_idx, len);
    end
    check(beat_idx == len, "R5", "beat count", beat_idx, len);
    check(ev_beat_idx == len, "R10", "beat event count", ev_beat_idx, len);
    check(irq_cnt == irq0 + 1, "R6", "irq pulses", irq_cnt, irq0 + 1);
    check(done_ev_cnt == done0 + 1, "R10", "done events", done_ev_cnt, done0 + 1);
    reg_read(4'h8, rd);
    check(rd == 0, "R2", "control after completion", rd, 0);
    reg_read(4'hC, rd);
    check(rd == 32'(sat_cnt(completions)), "R7", "completion counter", rd, sat_cnt(completions));
  endtask

  initial begin
    logic [31:0] rd;
    int c0, s0, irq0;
    void'($urandom(32'd2024));
    rst = 1'b1; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check(!st_valid && !mem_req && !irq_done && !evt_valid, "R11", "outputs after reset",
          {st_valid, mem_req, irq_done, evt_valid}, 0);
    for (int i = 0; i < 4; i++) begin
      reg_read(4'(i * 4), rd);
      check(rd == 0, "R11", "register after reset", rd, 0);
    end

    // R1 readback and cfg events
    c0 = cfg_ev_cnt;
    reg_write(4'h0, 32'h0000_1230);
    reg_write(4'h4, 32'd5);
    reg_read(4'h0, rd);
    check(rd == 32'h0000_1230, "R1", "source readback", rd, 32'h1230);
    reg_read(4'h4, rd);
    check(rd == 5, "R1", "count readback", rd, 5);
    reg_write(4'h8, 32'h0);
    check(cfg_ev_cnt == c0 + 3, "R10", "cfg event count", cfg_ev_cnt, c0 + 3);
    reg_read(4'h8, rd);
    check(rd == 0, "R2", "control write without start bit", rd, 0);

    // directed transfers
    xfer(32'h0000_0100, 4, 100);
    xfer(32'h0000_8000, 6, 30);
    xfer(32'h0000_4000, 0, 100);   // R8
    xfer(32'hFFFF_FFF8, 3, 70);    // address wrap

    // R6 / R9: long stall with writes attempted mid-transfer
    ready_pct = 0;
    reg_write(4'h0, 32'h0000_2000);
    reg_write(4'h4, 32'd3);
    x_src = 32'h0000_2000; x_len = 3;
    req_idx = 0; beat_idx = 0; ev_beat_idx = 0;
    irq0 = irq_cnt;
    reg_write(4'h8, 32'h1);
    while (!st_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    check(irq_cnt == irq0, "R6", "no completion under stall", irq_cnt, irq0);
    reg_read(4'h8, rd);
    check(rd == 1, "R2", "control busy bit", rd, 1);
    c0 = cfg_ev_cnt; s0 = start_ev_cnt;
    reg_write(4'h0, 32'h0000_FFF0);
    reg_write(4'h4, 32'd9);
    reg_write(4'h8, 32'h1);
    check(cfg_ev_cnt == c0 && start_ev_cnt == s0, "R9", "events from busy writes",
          cfg_ev_cnt + start_ev_cnt, c0 + s0);
    reg_read(4'h0, rd);
    check(rd == 32'h0000_2000, "R9", "source kept while busy", rd, 32'h2000);
    reg_read(4'h4, rd);
    check(rd == 3, "R9", "count kept while busy", rd, 3);
    ready_pct = 100;
    wait_irq(irq0);
    completions++;
    check(beat_idx == 3, "R9", "original length sent", beat_idx, 3);

    // R7 writes to the counter are ignored
    reg_write(4'hC, 32'h0);
    reg_read(4'hC, rd);
    check(rd == 32'(sat_cnt(completions)), "R7", "counter write ignored", rd, sat_cnt(completions));

    // random transfers, running the counter into saturation
    for (int n = 0; n < 14; n++) begin
      xfer(32'($urandom_range(0, 16'hFFFF)) << 2, $urandom_range(0, 10),
           $urandom_range(20, 100));
    end
    check(done_count == DW'(DMAX), "R7", "counter saturated", done_count, DMAX);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule